// File: doc/BRIEF.md
# Four-instruction single-cycle integer core

This block executes one 32-bit instruction word per clock from a tiny integer subset. The subset is add-immediate, register add, byte store and branch-if-equal. The instruction is presented on an input port. The core decodes it, reads two source registers from a 32-entry register file, and computes the outcome in the same cycle. On the next rising edge it commits that outcome to the register file and the program counter.

The byte store is presented combinationally on a memory write port: an enable, an address and a data byte. The core does not trap on anything. Instead it raises three flags:
- an unknown-instruction flag, for any word outside the subset;
- an environment-call flag, for one exact word;
- a fault flag, for a byte store that lands inside a protected code window.

A parameter selects a 32-bit or 64-bit machine word. Immediates are sign-extended to that width.

Internally each word is classified into one of five decode classes: `CL_ADDI`, `CL_ADD`, `CL_SB`, `CL_BEQ` and `CL_UNKNOWN`. The output process is a `unique case` over the class. The only stored state is the register file and the program counter. After reset, every cycle commits the class of the current word, and there are no multi-cycle transitions.

Top module: `rvm_core`

## Requirements
- R1: A word is known only when it matches one of these. Every other word, including near-misses in funct3 or funct7, asserts `unknown_o`.
  - Bits 6:0 = 0010011 with bits 14:12 = 000 (add-immediate).
  - Bits 6:0 = 0110011 with bits 14:12 = 000 and bits 31:25 = 0000000 (add).
  - Bits 6:0 = 0100011 with bits 14:12 = 000 (byte store).
  - Bits 6:0 = 1100011 with bits 14:12 = 000 (branch-if-equal).
- R2: Add-immediate writes the value of register bits 19:15 plus the sign-extended bits 31:20 into register bits 11:7.
- R3: Register add writes the sum of the registers named by bits 19:15 and 24:20 into register bits 11:7, wrapping at the word width.
- R4: A byte store drives `mem_we_o`=1. It drives `mem_addr_o` = rs1 + sign-extended {bits 31:25, bits 11:7}. It drives `mem_byte_o` = bits 7:0 of rs2. All three are valid in the cycle the word is presented.
- R5: Branch-if-equal with equal operands loads PC + offset. The offset is the sign-extended {bit 31, bit 7, bits 30:25, bits 11:8, 0}.
- R6: In every other case, including a branch with unequal operands, the PC advances by 4.
- R7: The register file does not change when the destination is register 0, or for stores and branches. Register 0 always reads as zero.
- R8: An unknown word writes no register and drives `mem_we_o` low.
- R9: `store_fault_o` is 1 exactly when a byte store's address is at or above `CODE_LO` and below `CODE_HI`.
- R10: `ecall_o` is 1 exactly when the whole word equals 32'h00000073. That word is also reported as unknown.
- R11: A synchronous reset clears the PC and all registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction word executed this cycle |
| pc_o | output | XLEN | Current program counter |
| mem_we_o | output | 1 | Byte store enable |
| mem_addr_o | output | XLEN | Byte store address |
| mem_byte_o | output | 8 | Byte store data |
| unknown_o | output | 1 | Word is outside the supported subset |
| ecall_o | output | 1 | Word is the environment-call encoding |
| store_fault_o | output | 1 | Byte store targets the code window |

## Verification
Flags and the memory write port are combinational, so they are due in the same cycle the word is driven. The bench sets the word just after a rising edge and samples these outputs at the following falling edge. Register writes and the next PC appear one rising edge later. The PC is sampled 1 ns after that edge. Register contents are read back one instruction later by issuing a zero-offset byte store from the register and comparing the store address. This keeps every read-back to the ports and to an edge already passed.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

    typedef enum logic [2:0] {
        CL_ADDI,
        CL_ADD,
        CL_SB,
        CL_BEQ,
        CL_UNKNOWN
    } instr_class_e;

    localparam logic [6:0]  OPC_IMM    = 7'b0010011;
    localparam logic [6:0]  OPC_REG    = 7'b0110011;
    localparam logic [6:0]  OPC_STORE  = 7'b0100011;
    localparam logic [6:0]  OPC_BRANCH = 7'b1100011;
    localparam logic [2:0]  F3_ZERO    = 3'b000;
    localparam logic [6:0]  F7_PLAIN   = 7'b0000000;
    localparam logic [31:0] ECALL_WORD = 32'h0000_0073;

    typedef struct packed {
        logic [4:0]   rd;
        logic [4:0]   rs1;
        logic [4:0]   rs2;
        instr_class_e cls;
        logic         is_ecall;
    } dec_t;

endpackage

// File: rtl/rvm_decode.sv
module rvm_decode
    import rvm_pkg::*;
(
    input  logic [31:0] instr_i,
    output dec_t        dec_o
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;

    assign opc = instr_i[6:0];
    assign f3  = instr_i[14:12];
    assign f7  = instr_i[31:25];

    always_comb begin
        dec_o.rd       = instr_i[11:7];
        dec_o.rs1      = instr_i[19:15];
        dec_o.rs2      = instr_i[24:20];
        dec_o.is_ecall = (instr_i == ECALL_WORD);
        dec_o.cls      = CL_UNKNOWN;
        unique case (opc)
            OPC_IMM:    if (f3 == F3_ZERO) dec_o.cls = CL_ADDI;
            OPC_REG:    if (f3 == F3_ZERO && f7 == F7_PLAIN) dec_o.cls = CL_ADD;
            OPC_STORE:  if (f3 == F3_ZERO) dec_o.cls = CL_SB;
            OPC_BRANCH: if (f3 == F3_ZERO) dec_o.cls = CL_BEQ;
            default:    dec_o.cls = CL_UNKNOWN;
        endcase
    end
endmodule

// File: rtl/rvm_imm.sv
module rvm_imm #(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr_i,
    output logic [XLEN-1:0] imm_i_o,
    output logic [XLEN-1:0] imm_s_o,
    output logic [XLEN-1:0] imm_b_o
);
    localparam int EXT12 = XLEN - 12;
    localparam int EXT13 = XLEN - 13;

    logic [11:0] raw_i;
    logic [11:0] raw_s;
    logic [12:0] raw_b;

    assign raw_i = instr_i[31:20];
    assign raw_s = {instr_i[31:25], instr_i[11:7]};
    assign raw_b = {instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};

    assign imm_i_o = {{EXT12{raw_i[11]}}, raw_i};
    assign imm_s_o = {{EXT12{raw_s[11]}}, raw_s};
    assign imm_b_o = {{EXT13{raw_b[12]}}, raw_b};
endmodule

// File: rtl/rvm_regfile.sv
module rvm_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we_i,
    input  logic [$clog2(NREG)-1:0] waddr_i,
    input  logic [XLEN-1:0]         wdata_i,
    input  logic [$clog2(NREG)-1:0] raddr1_i,
    input  logic [$clog2(NREG)-1:0] raddr2_i,
    output logic [XLEN-1:0]         rdata1_o,
    output logic [XLEN-1:0]         rdata2_o
);
    localparam int AW = $clog2(NREG);

    logic [XLEN-1:0] regs [NREG];

    assign regs[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        logic [XLEN-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we_i && waddr_i == AW'(g))
                q <= wdata_i;
        end
        assign regs[g] = q;
    end

    assign rdata1_o = regs[raddr1_i];
    assign rdata2_o = regs[raddr2_i];
endmodule

// File: rtl/rvm_core.sv
module rvm_core
    import rvm_pkg::*;
#(
    parameter bit          WORD64  = 1'b0,
    parameter int          XLEN    = WORD64 ? 64 : 32,
    parameter logic [63:0] CODE_LO = 64'h0,
    parameter logic [63:0] CODE_HI = 64'h400
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     instr_i,
    output logic [XLEN-1:0] pc_o,
    output logic            mem_we_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [7:0]      mem_byte_o,
    output logic            unknown_o,
    output logic            ecall_o,
    output logic            store_fault_o
);
    localparam logic [XLEN-1:0] SEG_LO = CODE_LO[XLEN-1:0];
    localparam logic [XLEN-1:0] SEG_HI = CODE_HI[XLEN-1:0];
    localparam logic [XLEN-1:0] STEP   = XLEN'(4);

    dec_t            dec;
    logic [XLEN-1:0] imm_i, imm_s, imm_b;
    logic [XLEN-1:0] rs1_val, rs2_val, wb_val, st_addr, pc_q, pc_next;
    logic            wb_en, st_en, br_take;

    rvm_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    rvm_imm #(.XLEN(XLEN)) u_imm (
        .instr_i (instr_i),
        .imm_i_o (imm_i),
        .imm_s_o (imm_s),
        .imm_b_o (imm_b)
    );

    rvm_regfile #(.XLEN(XLEN), .NREG(32)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .we_i     (wb_en),
        .waddr_i  (dec.rd),
        .wdata_i  (wb_val),
        .raddr1_i (dec.rs1),
        .raddr2_i (dec.rs2),
        .rdata1_o (rs1_val),
        .rdata2_o (rs2_val)
    );

    // per-class outputs
    always_comb begin
        wb_en   = 1'b0;
        wb_val  = rs1_val + imm_i;
        st_en   = 1'b0;
        br_take = 1'b0;
        unique case (dec.cls)
            CL_ADDI:    wb_en = 1'b1;
            CL_ADD: begin
                wb_en  = 1'b1;
                wb_val = rs1_val + rs2_val;
            end
            CL_SB:      st_en = 1'b1;
            CL_BEQ:     br_take = (rs1_val == rs2_val);
            CL_UNKNOWN: wb_en = 1'b0;
            default:    wb_en = 1'b0;
        endcase
    end

    assign st_addr = rs1_val + imm_s;
    assign pc_next = br_take ? (pc_q + imm_b) : (pc_q + STEP);

    // program counter register
    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= pc_next;
    end

    assign pc_o          = pc_q;
    assign mem_we_o      = st_en;
    assign mem_addr_o    = st_addr;
    assign mem_byte_o    = rs2_val[7:0];
    assign unknown_o     = (dec.cls == CL_UNKNOWN);
    assign ecall_o       = dec.is_ecall;
    assign store_fault_o = st_en && (st_addr >= SEG_LO) && (st_addr < SEG_HI);
endmodule

// File: rtl/rvm_core_chk.sv
module rvm_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] pc,
    input logic            mem_we,
    input logic            unknown,
    input logic            ecall,
    input logic            fault,
    input logic [XLEN-1:0] rs1_val,
    input logic [XLEN-1:0] rs2_val,
    input logic [XLEN-1:0] b_imm
);
    logic beq_word;
    assign beq_word = (instr[6:0] == 7'b1100011) && (instr[14:12] == 3'b000);

    assert_branch_target_R5: assert property (@(posedge clk) disable iff (rst)
        (beq_word && rs1_val == rs2_val) |=> (pc == $past(pc) + $past(b_imm)));

    assert_seq_step_R6: assert property (@(posedge clk) disable iff (rst)
        !(beq_word && rs1_val == rs2_val) |=> (pc == $past(pc) + XLEN'(4)));

    assert_unknown_no_store_R8: assert property (@(posedge clk) disable iff (rst)
        unknown |-> !mem_we);

    assert_fault_on_store_R9: assert property (@(posedge clk) disable iff (rst)
        fault |-> mem_we);

    assert_ecall_unknown_R10: assert property (@(posedge clk) disable iff (rst)
        ecall |-> (unknown && instr == 32'h0000_0073));

    assert_reset_pc_R11: assert property (@(posedge clk)
        rst |=> (pc == '0));
endmodule

bind rvm_core rvm_core_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .instr   (instr_i),
    .pc      (pc_o),
    .mem_we  (mem_we_o),
    .unknown (unknown_o),
    .ecall   (ecall_o),
    .fault   (store_fault_o),
    .rs1_val (rs1_val),
    .rs2_val (rs2_val),
    .b_imm   (imm_b)
);

// File: tb/tb_rvm_core.sv
module tb_rvm_core;
    localparam logic [31:0] SEG_LO = 32'h0;
    localparam logic [31:0] SEG_HI = 32'h400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic [31:0] pc_o, mem_addr_o;
    logic [7:0]  mem_byte_o;
    logic        mem_we_o, unknown_o, ecall_o, store_fault_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] mreg [32];
    logic [31:0] pc_exp;

    always #5 clk = ~clk;

    rvm_core dut (
        .clk(clk), .rst(rst), .instr_i(instr), .pc_o(pc_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_byte_o(mem_byte_o),
        .unknown_o(unknown_o), .ecall_o(ecall_o), .store_fault_o(store_fault_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] e_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] e_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1, logic [4:0] rd);
        return {f7, rs2, rs1, 3'b000, rd, 7'b0110011};
    endfunction
    function automatic logic [31:0] e_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1, logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] e_b(logic [12:0] imm, logic [4:0] rs2, logic [4:0] rs1, logic [2:0] f3);
        return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'b1100011};
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        chk("R11", "pc after reset", pc_o, 32'h0);
        for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
        pc_exp = 32'h0;
    endtask

    // Drive one word just after a rising edge, check combinational results at
    // the falling edge, then the committed PC after the next rising edge.
    task automatic exec(input logic [31:0] w, input string tag);
        logic [31:0] a, b, ii, si, bi, addr;
        logic        is_addi, is_add, is_sb, is_beq, kn;
        instr = w;
        a  = mreg[w[19:15]];
        b  = mreg[w[24:20]];
        ii = {{20{w[31]}}, w[31:20]};
        si = {{20{w[31]}}, w[31:25], w[11:7]};
        bi = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        is_addi = (w[6:0] == 7'b0010011) && (w[14:12] == 3'b000);
        is_add  = (w[6:0] == 7'b0110011) && (w[14:12] == 3'b000) && (w[31:25] == 7'b0);
        is_sb   = (w[6:0] == 7'b0100011) && (w[14:12] == 3'b000);
        is_beq  = (w[6:0] == 7'b1100011) && (w[14:12] == 3'b000);
        kn      = is_addi | is_add | is_sb | is_beq;
        addr    = a + si;
        @(negedge clk); #1;
        chk(tag, "unknown flag", {31'b0, unknown_o}, {31'b0, !kn});
        chk(tag, "ecall flag", {31'b0, ecall_o}, {31'b0, w == 32'h73});
        chk(tag, "store enable", {31'b0, mem_we_o}, {31'b0, is_sb});
        if (is_sb) begin
            chk(tag, "store address", mem_addr_o, addr);
            chk(tag, "store byte", {24'b0, mem_byte_o}, {24'b0, b[7:0]});
            chk(tag, "store fault", {31'b0, store_fault_o},
                {31'b0, (addr >= SEG_LO) && (addr < SEG_HI)});
        end
        @(posedge clk); #1;
        if (is_addi && w[11:7] != 5'd0) mreg[w[11:7]] = a + ii;
        if (is_add  && w[11:7] != 5'd0) mreg[w[11:7]] = a + b;
        pc_exp = (is_beq && a == b) ? pc_exp + bi : pc_exp + 32'd4;
        chk(tag, "next pc", pc_o, pc_exp);
    endtask

    // read a register back via a zero-offset byte store
    task automatic peek(input int r, input string tag);
        exec(e_s(12'h0, 5'd0, 5'(r), 3'b000), tag);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL R6 watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R11: every register clear after reset
        for (int r = 0; r < 32; r++) peek(r, "R11");

        // R2: add-immediate, one immediate bit at a time, then boundary values
        for (int k = 0; k < 12; k++) exec(e_i(12'(1 << k), 5'd0, 3'b000, 5'(k + 1), 7'b0010011), "R2");
        exec(e_i(12'h7FF, 5'd0, 3'b000, 5'd13, 7'b0010011), "R2");
        exec(e_i(12'h800, 5'd0, 3'b000, 5'd14, 7'b0010011), "R2");
        exec(e_i(12'hFFF, 5'd13, 3'b000, 5'd15, 7'b0010011), "R2");
        exec(e_i(12'h001, 5'd14, 3'b000, 5'd16, 7'b0010011), "R2");
        for (int r = 1; r < 17; r++) peek(r, "R2");

        // R7: destination register 0 never changes
        exec(e_i(12'h123, 5'd13, 3'b000, 5'd0, 7'b0010011), "R7");
        exec(e_r(7'b0, 5'd13, 5'd13, 5'd0), "R7");
        peek(0, "R7");

        // R3: register add, including wrap
        exec(e_i(12'hFFF, 5'd0, 3'b000, 5'd20, 7'b0010011), "R3");
        exec(e_r(7'b0, 5'd20, 5'd20, 5'd21), "R3");
        exec(e_r(7'b0, 5'd13, 5'd14, 5'd22), "R3");
        exec(e_r(7'b0, 5'd20, 5'd16, 5'd23), "R3");
        exec(e_r(7'b0, 5'd23, 5'd23, 5'd23), "R3");
        for (int r = 20; r < 24; r++) peek(r, "R3");

        // R1 and R8: near-miss encodings are unknown and write nothing
        exec(e_r(7'b0100000, 5'd13, 5'd13, 5'd24), "R1");
        exec(e_r(7'b0000001, 5'd13, 5'd13, 5'd25), "R1");
        exec(e_i(12'h005, 5'd13, 3'b010, 5'd26, 7'b0010011), "R1");
        exec(e_i(12'h005, 5'd13, 3'b000, 5'd27, 7'b0000011), "R8");
        exec(e_s(12'h010, 5'd13, 5'd0, 3'b001), "R8");
        for (int r = 24; r < 28; r++) peek(r, "R8");

        // R4: store offset bit sweep, data byte from rs2
        for (int k = 0; k < 12; k++) exec(e_s(12'(1 << k), 5'd13, 5'd0, 3'b000), "R4");
        exec(e_s(12'h7F0, 5'd21, 5'd13, 3'b000), "R4");
        // R7: store with a nonzero bits 11:7 does not touch that register
        exec(e_s(12'h005, 5'd13, 5'd13, 3'b000), "R7");
        peek(5, "R7");

        // R9: code window boundaries
        exec(e_i(12'h3FF, 5'd0, 3'b000, 5'd10, 7'b0010011), "R9");
        exec(e_s(12'h000, 5'd13, 5'd10, 3'b000), "R9");
        exec(e_s(12'h001, 5'd13, 5'd10, 3'b000), "R9");
        exec(e_s(12'hFFF, 5'd13, 5'd0, 3'b000), "R9");
        exec(e_s(12'h000, 5'd13, 5'd0, 3'b000), "R9");

        // R5: taken branches, offset bit sweep and negative offsets
        for (int k = 1; k < 13; k++) exec(e_b(13'(1 << k), 5'd0, 5'd0, 3'b000), "R5");
        exec(e_b(13'h1FF0, 5'd13, 5'd13, 3'b000), "R5");
        exec(e_b(13'h0FFE, 5'd21, 5'd21, 3'b000), "R5");
        // R7: branch leaves registers alone
        exec(e_b(13'h0008, 5'd6, 5'd6, 3'b000), "R7");
        peek(6, "R7");

        // R6: unequal operands and other branch conditions fall through
        exec(e_b(13'h0040, 5'd13, 5'd14, 3'b000), "R6");
        exec(e_b(13'h0040, 5'd13, 5'd14, 3'b001), "R6");
        exec(e_b(13'h0040, 5'd0, 5'd0, 3'b001), "R6");

        // R10: environment call word and a neighbour
        exec(32'h0000_0073, "R10");
        exec(32'h0010_0073, "R10");
        exec(32'h0000_00F3, "R10");

        // R11: reset mid-run clears state again
        do_reset();
        for (int r = 13; r < 24; r++) peek(r, "R11");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule